// File: doc/BRIEF.md
# Strided Vector Load over Interleaved Banks

This unit fills a 64-entry vector register from a memory spread across four banks with low-order interleaving: word address `n` lives in bank `n mod 4`. A load starts with a one-cycle `start` pulse carrying a base address, a signed stride and an element count. The unit then generates the element addresses one after another, steers each one to its bank, and keeps a per-bank busy timer so that it never asks a bank for a new word while that bank is still busy with the previous one.

Returned words are written into the vector register at the index of the element that asked for them. The register is read through a separate combinational port. The stride sets the overlap. Unit stride rotates through all four banks, so one element is issued every cycle. A stride that is a multiple of four keeps hitting one bank, so every element pays the full bank time.

The control is a four-state machine:
- **IDLE** waits for `start`. It moves to **ISSUE**, or straight to **FINISH** when the count is zero.
- **ISSUE** offers one request per cycle when the target bank is free. After the last element is accepted it moves to **DRAIN**.
- **DRAIN** waits until every outstanding word has been written. It then moves to **FINISH**.
- **FINISH** drives `done` for one cycle and returns to **IDLE**.

Top module: `strided_vload`

## Requirements
- R1: While reset is held, and in the first cycle after it, `done` is low and no `bank_req` bit is set.
- R2: Element i is fetched from word address (base + i*stride) mod 2^16, with stride taken as signed 16-bit. Its request goes on `bank_req[a mod 4]`, where `a` is the address on `bank_addr`. Elements are accepted in increasing order of i.
- R3: At most one `bank_req` bit is high in any cycle, and a transfer happens only when `bank_req[b]` and `bank_ready[b]` are both high. After bank b accepts a request, `bank_req[b]` stays low for the next 3 cycles. Exactly as many transfers occur as elements are loaded.
- R4: A word returned with `bank_rvalid[b]` is written to the vector entry of the element last accepted by bank b. `rd_data` shows entry `rd_idx` combinationally.
- R5: Element i is accepted at the earliest edge that is at least one edge after element i-1, and at least four edges after the previous acceptance by the same bank. Element 0 is accepted at the first edge after `start` is sampled. Example: stride 1 with 64 elements finishes in 68 cycles; stride 4 costs 4 cycles per element.
- R6: Vector entries at indices at or above the loaded count keep their previous contents.
- R7: `done` rises in the cycle after the edge that writes the last returned word, and it lasts exactly one cycle.
- R8: A count of 0 raises `done` in the cycle right after `start` is sampled, with no bank request.
- R9: A `start` pulse while a load is in progress is ignored.
- R10: A count above 64 is treated as 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a load (sampled in IDLE only) |
| base | input | 16 | Word address of element 0 |
| stride | input | 16 | Signed address step between elements |
| vlen | input | 7 | Number of elements, clamped to 64 |
| done | output | 1 | One-cycle completion pulse |
| bank_req | output | 4 | Per-bank request, at most one bit set |
| bank_addr | output | 16 | Word address of the offered request |
| bank_ready | input | 4 | Per-bank acceptance |
| bank_rvalid | input | 4 | Per-bank returned-word strobe |
| bank_rdata | input | 128 | Per-bank returned words, bank b in bits 32b+31:32b |
| rd_idx | input | 6 | Vector register read index |
| rd_data | output | 32 | Vector register read data |

## Verification
The loads cover several stride cases:
- **Unit stride:** rotates through all banks and shows full overlap.
- **Stride 4:** pins one bank and exposes the whole bank time per element.
- **Stride 2:** alternates two banks and sits between the two.
- **Negative stride with address wrap:** separates correct modular arithmetic from sign mistakes.

Each load is timed against a model of when elements can be accepted, so a wrongly counted busy window shows up as a cycle-count error even when the data is right.

Further loads cover a short count after a full one, to confirm that the upper entries are untouched; a zero count; an oversized count; and a stray `start` during a load.

// File: rtl/svl_pkg.sv
package svl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_DRAIN,
        ST_FIN
    } svl_state_e;

endpackage

// File: rtl/svl_bank_timer.sv
module svl_bank_timer #(
    parameter int BUSY_CYC = 4,
    localparam int CW = $clog2(BUSY_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    output logic busy
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (accept)
            cnt <= CW'(BUSY_CYC - 1);
        else if (cnt != '0)
            cnt <= cnt - CW'(1);
    end

    assign busy = (cnt != '0);

endmodule

// File: rtl/svl_vreg.sv
module svl_vreg #(
    parameter int DEPTH = 64,
    parameter int DW    = 32,
    parameter int NWR   = 4,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic [NWR-1:0]    we,
    input  logic [NWR*IW-1:0] widx,
    input  logic [NWR*DW-1:0] wdata,
    input  logic [IW-1:0]     rd_idx,
    output logic [DW-1:0]     rd_data
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        for (int p = 0; p < NWR; p++) begin
            if (we[p])
                mem[widx[p*IW +: IW]] <= wdata[p*DW +: DW];
        end
    end

    assign rd_data = mem[rd_idx];

endmodule

// File: rtl/strided_vload.sv
module strided_vload
    import svl_pkg::*;
#(
    parameter int NBANK    = 4,
    parameter int AW       = 16,
    parameter int DW       = 32,
    parameter int MAXVL    = 64,
    parameter int BUSY_CYC = 4,
    localparam int BSEL    = $clog2(NBANK),
    localparam int IW      = $clog2(MAXVL),
    localparam int LW      = $clog2(MAXVL + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [AW-1:0]       base,
    input  logic [AW-1:0]       stride,
    input  logic [LW-1:0]       vlen,
    output logic                done,
    output logic [NBANK-1:0]    bank_req,
    output logic [AW-1:0]       bank_addr,
    input  logic [NBANK-1:0]    bank_ready,
    input  logic [NBANK-1:0]    bank_rvalid,
    input  logic [NBANK*DW-1:0] bank_rdata,
    input  logic [IW-1:0]       rd_idx,
    output logic [DW-1:0]       rd_data
);

    svl_state_e state, state_nx;

    logic [LW-1:0]    len_q, iss_cnt, rcv_cnt, nwr, eff_len;
    logic [AW-1:0]    cur_addr, stride_q;
    logic [BSEL-1:0]  cur_bank;
    logic [NBANK-1:0] bank_busy, bank_acc;
    logic             accept, last_issue, all_written;
    logic [IW-1:0]    pend_idx [NBANK];
    logic [NBANK*IW-1:0] pend_flat;

    assign eff_len  = (vlen > LW'(MAXVL)) ? LW'(MAXVL) : vlen;
    assign cur_bank = cur_addr[BSEL-1:0];
    assign bank_acc = bank_req & bank_ready;
    assign accept   = |bank_acc;
    assign last_issue  = accept && (iss_cnt == len_q - LW'(1));
    assign all_written = (rcv_cnt + nwr) == len_q;

    always_comb begin
        nwr = '0;
        for (int b = 0; b < NBANK; b++)
            nwr = nwr + LW'(bank_rvalid[b]);
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        svl_bank_timer #(.BUSY_CYC(BUSY_CYC)) u_timer (
            .clk    (clk),
            .rst_n  (rst_n),
            .accept (bank_acc[b]),
            .busy   (bank_busy[b])
        );
        assign pend_flat[b*IW +: IW] = pend_idx[b];
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = (eff_len == '0) ? ST_FIN : ST_ISSUE;
            ST_ISSUE: if (last_issue) state_nx = ST_DRAIN;
            ST_DRAIN: if (all_written) state_nx = ST_FIN;
            ST_FIN:   state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        bank_req  = '0;
        bank_addr = cur_addr;
        done      = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_ISSUE: if (!bank_busy[cur_bank]) bank_req[cur_bank] = 1'b1;
            ST_DRAIN: ;
            ST_FIN:   done = 1'b1;
        endcase
    end

    // address walk, counters and per-bank element tags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q    <= '0;
            iss_cnt  <= '0;
            rcv_cnt  <= '0;
            cur_addr <= '0;
            stride_q <= '0;
            for (int b = 0; b < NBANK; b++) pend_idx[b] <= '0;
        end else begin
            if (state == ST_IDLE && start) begin
                len_q    <= eff_len;
                iss_cnt  <= '0;
                rcv_cnt  <= '0;
                cur_addr <= base;
                stride_q <= stride;
            end else begin
                if (accept) begin
                    iss_cnt  <= iss_cnt + LW'(1);
                    cur_addr <= cur_addr + stride_q;
                end
                rcv_cnt <= rcv_cnt + nwr;
            end
            for (int b = 0; b < NBANK; b++)
                if (bank_acc[b]) pend_idx[b] <= iss_cnt[IW-1:0];
        end
    end

    svl_vreg #(.DEPTH(MAXVL), .DW(DW), .NWR(NBANK)) u_vreg (
        .clk     (clk),
        .we      (bank_rvalid),
        .widx    (pend_flat),
        .wdata   (bank_rdata),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/svl_checker.sv
module svl_checker #(
    parameter int NBANK    = 4,
    parameter int BUSY_CYC = 4,
    parameter int LW       = 7,
    localparam int BSEL    = $clog2(NBANK),
    localparam int SW      = $clog2(BUSY_CYC + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [LW-1:0]    vlen,
    input logic [NBANK-1:0] req,
    input logic [NBANK-1:0] ready,
    input logic [BSEL-1:0]  addr_lsb,
    input logic             done
);

    logic          act;
    logic [SW-1:0] since [NBANK];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act <= 1'b0;
            for (int b = 0; b < NBANK; b++) since[b] <= SW'(BUSY_CYC);
        end else begin
            if (start && !act) act <= 1'b1;
            else if (done)     act <= 1'b0;
            for (int b = 0; b < NBANK; b++) begin
                if (req[b] && ready[b])         since[b] <= SW'(1);
                else if (since[b] < SW'(BUSY_CYC)) since[b] <= since[b] + SW'(1);
            end
        end
    end

    a_r3_single_req: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req));

    a_r2_bank_route: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |-> req[addr_lsb]);

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_no_req_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (req == '0));

    a_r8_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !act && vlen == '0) |=> (done && req == '0));

    for (genvar b = 0; b < NBANK; b++) begin : g_gap
        a_r3_bank_gap: assert property (@(posedge clk) disable iff (!rst_n)
            req[b] |-> (since[b] >= SW'(BUSY_CYC)));
    end

endmodule

bind strided_vload svl_checker #(
    .NBANK(NBANK), .BUSY_CYC(BUSY_CYC), .LW(LW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .vlen     (vlen),
    .req      (bank_req),
    .ready    (bank_ready),
    .addr_lsb (bank_addr[BSEL-1:0]),
    .done     (done)
);

// File: tb/sim_strided_vload.sv
`timescale 1ns/1ps
module sim_strided_vload;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] base = '0, stride = '0;
    logic [6:0]  vlen = '0;
    logic        done;
    logic [3:0]  req, ready, rvalid;
    logic [15:0] addr;
    logic [127:0] rdata;
    logic [5:0]  rd_idx = '0;
    logic [31:0] rd_data;

    always #2.5 clk = ~clk;

    strided_vload u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .base(base), .stride(stride),
        .vlen(vlen), .done(done), .bank_req(req), .bank_addr(addr),
        .bank_ready(ready), .bank_rvalid(rvalid), .bank_rdata(rdata),
        .rd_idx(rd_idx), .rd_data(rd_data)
    );

    int checks = 0, fails = 0, cyc = 0, acc_cnt = 0;
    bit finished = 0, mon_done = 0;
    event ev_chk;

    typedef struct { int idx; logic [31:0] val; } item_t;
    item_t       exp_q [$];
    logic [15:0] exp_addr [$];
    logic [31:0] shadow [64];

    function automatic logic [31:0] wordval(input logic [15:0] a);
        return {a ^ 16'hC35A, a + 16'h1111};
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", rq, act, expv);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // behavioural banks: busy for 4 cycles, word returned on the 4th
    int          bcnt [4];
    logic [15:0] baddr [4];
    initial for (int b = 0; b < 4; b++) begin bcnt[b] = 0; baddr[b] = '0; end

    always_comb begin
        for (int b = 0; b < 4; b++) begin
            ready[b]  = (bcnt[b] <= 1);
            rvalid[b] = (bcnt[b] == 1);
            rdata[b*32 +: 32] = wordval(baddr[b]);
        end
    end

    always @(posedge clk) begin
        for (int b = 0; b < 4; b++) begin
            if (req[b] && ready[b]) begin
                bcnt[b]  <= 4;
                baddr[b] <= addr;
            end else if (bcnt[b] > 0) begin
                bcnt[b] <= bcnt[b] - 1;
            end
        end
    end

    // request monitor: address order and bank routing (R2)
    always @(negedge clk) begin
        if (rst_n && |(req & ready)) begin
            acc_cnt++;
            if (exp_addr.size() == 0)
                chk(1'b0, "R2 unexpected request", {16'h0, addr}, 32'h0);
            else begin
                logic [15:0] e;
                e = exp_addr.pop_front();
                chk(addr == e, "R2 address", {16'h0, addr}, {16'h0, e});
                chk(req[addr[1:0]] == 1'b1, "R2 bank select", {28'h0, req}, 32'(1 << addr[1:0]));
            end
        end
    end

    // scoreboard monitor: pops expected vector entries and reads them back
    initial begin
        forever begin
            @(ev_chk);
            while (exp_q.size() > 0) begin
                item_t it;
                it = exp_q.pop_front();
                rd_idx = 6'(it.idx);
                #1;
                chk(rd_data == it.val, "R4,R6 vector entry", rd_data, it.val);
            end
            mon_done = 1;
        end
    end

    task automatic run_load(input logic [15:0] b, input logic [15:0] s,
                            input logic [6:0] v, input bit glitch, input string tag);
        int n, t, exp_lat, c0, k, lat;
        int last [4];
        n = (v > 64) ? 64 : int'(v);
        t = 0;
        for (int j = 0; j < 4; j++) last[j] = -100;
        for (int i = 0; i < n; i++) begin
            logic [15:0] a;
            int bk;
            a  = 16'(b + i * s);
            bk = int'(a[1:0]);
            t  = (t + 1 > last[bk] + 4) ? t + 1 : last[bk] + 4;
            last[bk] = t;
            exp_addr.push_back(a);
            shadow[i] = wordval(a);
        end
        exp_lat = (n == 0) ? 0 : t + 4;

        @(negedge clk);
        base = b; stride = s; vlen = v; start = 1'b1; acc_cnt = 0; c0 = cyc;
        @(negedge clk);
        start = 1'b0;
        k = 0;
        while (!done && k < 2000) begin
            @(negedge clk);
            k++;
            if (glitch && k == 3) begin
                start = 1'b1; base = 16'h7777; vlen = 7'd5;
            end else begin
                start = 1'b0;
            end
        end
        lat = cyc - c0 - 1;
        chk(lat == exp_lat, {tag, " R5,R7 cycles to done"}, 32'(lat), 32'(exp_lat));
        chk(acc_cnt == n, {tag, " R3 transfer count"}, 32'(acc_cnt), 32'(n));
        chk(exp_addr.size() == 0, {tag, " R2 all elements issued"}, 32'(exp_addr.size()), 32'h0);
        exp_addr.delete();
        @(negedge clk);
        chk(done == 1'b0, {tag, " R7 done one cycle"}, {31'h0, done}, 32'h0);

        for (int i = 0; i < 64; i++) begin
            item_t it;
            it.idx = i; it.val = shadow[i];
            exp_q.push_back(it);
        end
        mon_done = 0;
        -> ev_chk;
        wait (mon_done);
        repeat (6) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) shadow[i] = '0;
        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R1 done in reset", {31'h0, done}, 32'h0);
        chk(req == 4'h0, "R1 req in reset", {28'h0, req}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 1'b0 && req == 4'h0, "R1 after reset", {27'h0, req, done}, 32'h0);

        run_load(16'h0100, 16'd1,    7'd64,  0, "unit");         // R5 full overlap
        run_load(16'h0010, 16'd4,    7'd16,  0, "stride4");      // R5 conflicts
        run_load(16'h0003, 16'd2,    7'd12,  0, "stride2");
        run_load(16'h0002, 16'hFFFD, 7'd20,  0, "negwrap");      // R2 wrap
        run_load(16'h4000, 16'd1,    7'd10,  0, "short");        // R6 upper entries kept
        run_load(16'h2222, 16'd1,    7'd0,   0, "zero");         // R8
        run_load(16'hFFF0, 16'd3,    7'd100, 0, "clamp");        // R10
        run_load(16'h0500, 16'd5,    7'd30,  1, "restart");      // R9

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule